// File: doc/BRIEF.md
# Three-Bank GPIO Controller

This block is a memory-mapped general-purpose I/O controller with three banks of up to 32 pins each. It sits behind a plain 32-bit register bus that has a byte address, a write strobe and write data. Read data is combinational from the address. For each pin the block drives an output enable and an output value toward the pad, and it samples the pad input through a two-flop synchroniser.

Each bank has the following registers:
- a direction mask and a per-pin polarity inversion mask;
- an output latch, which can be written whole or changed atomically through write-one-to-set, write-one-to-clear and write-one-to-toggle aliases;
- separate rising-edge and falling-edge interrupt enables;
- an interrupt status and an edge status, both cleared by writing ones.

Every interrupt status bit of every bank feeds a single interrupt line.

Software numbers the pins of bank b from 32·b upward. The pad vectors follow the same numbering, so bank b pin i is pad index 32·b+i.

Top module: `banked_gpio`

## Requirements
- R1: After reset every pin is an input. `pad_oe` and `pad_out` are all zero, `irq` is low, and every readable register reads 0.
- R2: A direction bit of 1 makes the pin an output: its `pad_oe` bit is 1. A direction bit of 0 makes it an input. `pad_oe` changes only on a write to a direction register.
- R3: Register byte addresses are as follows. Registers that are not readable read as 0.

  | Register | Bank 0 | Bank 1 | Bank 2 |
  |---|---|---|---|
  | interrupt status | 0x00 | 0x38 | 0x60 |
  | edge status | 0x04 | 0x3C | 0x64 |
  | rising enable | 0x08 | 0x40 | 0x68 |
  | falling enable | 0x0C | 0x44 | 0x6C |
  | data | 0x20 | 0x48 | 0x70 |
  | direction | 0x24 | 0x4C | 0x74 |
  | polarity | 0x28 | 0x50 | 0x78 |
  | set (write-only) | 0x2C | 0x54 | 0x7C |
  | clear (write-only) | 0x30 | 0x58 | 0x80 |
  | toggle (write-only) | 0x34 | 0x5C | 0x84 |
- R4: A write to the set alias makes every latch bit whose write-data bit is 1 go to 1 on the next clock edge. A write to the clear alias makes every such latch bit go to 0. Latch bits whose write-data bit is 0 keep their value. A write to the data register loads the latch directly.
- R5: A write to the toggle alias inverts, on the next clock edge, every latch bit whose write-data bit is 1.
- R6: Reading the data register returns the latch bit for output pins. For input pins it returns the synchronised pad level XOR the polarity bit. A pad change becomes visible after two clock edges.
- R7: `pad_out` is the latch XOR polarity. A polarity bit of 1 also inverts the sense of the input for data reads and for edge detection.
- R8: On input pins only, a rising (falling) edge of the polarity-adjusted input sets the pin's interrupt status bit if its rising (falling) enable bit is 1. Any such edge sets the edge status bit, whatever the enables. The bit is set on the third clock edge after the pad change. Output pins never set either status bit.
- R9: `irq` is the OR of all interrupt status bits of all banks. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: Bank b pin i is pad index 32·b+i on `pad_in`, `pad_oe` and `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 96 | Pad input levels, 32 per bank |
| pad_oe | output | 96 | Pad output enables |
| pad_out | output | 96 | Pad output values |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle, against the bank 0 output latch:
- the one-cycle effect of set, clear and toggle writes;
- that the output enables hold still except on a direction write;
- that no status bit ever rises on an output pin;
- that `irq` never rises without a qualifying edge event one cycle earlier.

Other behaviour shows only in the bench's scenarios:
- the exact register map;
- the two-edge and three-edge latencies from pad to data read and from pad to interrupt;
- the split between gated interrupt status and ungated edge status;
- the effect of polarity on both outputs and edge sense.

// File: rtl/banked_gpio.sv
module banked_gpio #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3*NPIN-1:0] pad_in,
  output logic [3*NPIN-1:0] pad_oe,
  output logic [3*NPIN-1:0] pad_out,
  output logic              irq
);
  localparam int NB = 3;
  localparam int NR = 10;
  localparam int W  = NB * NPIN;

  // register index: 0 int, 1 edge, 2 rise en, 3 fall en, 4 data,
  // 5 dir, 6 pol, 7 set, 8 clear, 9 toggle
  function automatic logic [AW-1:0] reg_at(input int b, input int k);
    int off;
    if (b == 0) off = (k < 4) ? 4 * k : 32 + 4 * (k - 4);
    else        off = ((b == 1) ? 'h38 : 'h60) + 4 * k;
    return AW'(off);
  endfunction

  logic [W-1:0]       lat_all, dir_all, ist_all, ev_all;
  logic [NB*NR*NPIN-1:0] rd_all;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [NPIN-1:0] wd, s1, s2, prv, lat, dir, pol, ren, fen, ist, est;
    logic [NPIN-1:0] cur, old, rise, fall, ev;
    logic [NR-1:0]   hit;

    assign wd = bus_wdata[NPIN-1:0];
    for (genvar k = 0; k < NR; k++) begin : g_hit
      assign hit[k] = bus_wen && (bus_addr == reg_at(b, k));
    end

    assign cur  = s2 ^ pol;
    assign old  = prv ^ pol;
    assign rise = cur & ~old & ~dir;
    assign fall = ~cur & old & ~dir;
    assign ev   = (rise & ren) | (fall & fen);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= '0; s2 <= '0; prv <= '0;
        lat <= '0; dir <= '0; pol <= '0;
        ren <= '0; fen <= '0; ist <= '0; est <= '0;
      end else begin
        s1  <= pad_in[b*NPIN +: NPIN];
        s2  <= s1;
        prv <= s2;
        if (hit[2]) ren <= wd;
        if (hit[3]) fen <= wd;
        if (hit[5]) dir <= wd;
        if (hit[6]) pol <= wd;
        if (hit[4])      lat <= wd;
        else if (hit[7]) lat <= lat | wd;
        else if (hit[8]) lat <= lat & ~wd;
        else if (hit[9]) lat <= lat ^ wd;
        ist <= (ist & ~(hit[0] ? wd : '0)) | ev;
        est <= (est & ~(hit[1] ? wd : '0)) | rise | fall;
      end
    end

    assign pad_oe [b*NPIN +: NPIN] = dir;
    assign pad_out[b*NPIN +: NPIN] = lat ^ pol;
    assign lat_all[b*NPIN +: NPIN] = lat;
    assign dir_all[b*NPIN +: NPIN] = dir;
    assign ist_all[b*NPIN +: NPIN] = ist;
    assign ev_all [b*NPIN +: NPIN] = ev;

    assign rd_all[(b*NR+0)*NPIN +: NPIN] = ist;
    assign rd_all[(b*NR+1)*NPIN +: NPIN] = est;
    assign rd_all[(b*NR+2)*NPIN +: NPIN] = ren;
    assign rd_all[(b*NR+3)*NPIN +: NPIN] = fen;
    assign rd_all[(b*NR+4)*NPIN +: NPIN] = (dir & lat) | (~dir & cur);
    assign rd_all[(b*NR+5)*NPIN +: NPIN] = dir;
    assign rd_all[(b*NR+6)*NPIN +: NPIN] = pol;
    assign rd_all[(b*NR+7)*NPIN +: 3*NPIN] = '0;
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < NR; k++)
        if (bus_addr == reg_at(b, k))
          bus_rdata[NPIN-1:0] = rd_all[(b*NR+k)*NPIN +: NPIN];
  end

  assign irq = |ist_all;
endmodule

module banked_gpio_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wen,
  input logic [31:0]     bus_wdata,
  input logic [NPIN-1:0] lat0,
  input logic [NPIN-1:0] dir0,
  input logic [NPIN-1:0] ist0,
  input logic [NPIN-1:0] oe0,
  input logic            ev_any,
  input logic            irq
);
  logic [NPIN-1:0] wd;
  assign wd = bus_wdata[NPIN-1:0];

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == AW'('h2C)) |=> ((lat0 & $past(wd)) == $past(wd)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == AW'('h30)) |=> ((lat0 & $past(wd)) == '0));
  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == AW'('h34)) |=> (lat0 == ($past(lat0) ^ $past(wd))));
  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wen && bus_addr == AW'('h24)) |=> $stable(oe0));
  assert_outpin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ist0 & ~$past(ist0) & $past(dir0)) == '0));
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_any));
endmodule

bind banked_gpio banked_gpio_chk #(.NPIN(NPIN), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .lat0(lat_all[NPIN-1:0]), .dir0(dir_all[NPIN-1:0]),
  .ist0(ist_all[NPIN-1:0]), .oe0(pad_oe[NPIN-1:0]), .ev_any(|ev_all),
  .irq(irq));

// File: tb/banked_gpio_test.sv
module banked_gpio_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] pad_in = '0;
  logic [95:0] pad_oe, pad_out;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  banked_gpio uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq(irq));

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [11] = '{
    {8'h24, 32'hFFFF_FFFF, 8'h24, 32'hFFFF_FFFF},
    {8'h20, 32'h0000_00F0, 8'h20, 32'h0000_00F0},
    {8'h2C, 32'h0000_000F, 8'h20, 32'h0000_00FF},
    {8'h30, 32'h0000_0030, 8'h20, 32'h0000_00CF},
    {8'h34, 32'h0000_0101, 8'h20, 32'h0000_01CE},
    {8'h4C, 32'hFFFF_0000, 8'h4C, 32'hFFFF_0000},
    {8'h54, 32'hAAAA_AAAA, 8'h48, 32'hAAAA_0000},
    {8'h5C, 32'hFFFF_FFFF, 8'h48, 32'h5555_0000},
    {8'h74, 32'h0000_00FF, 8'h74, 32'h0000_00FF},
    {8'h7C, 32'h0000_0F0F, 8'h70, 32'h0000_000F},
    {8'h78, 32'h0000_FF00, 8'h70, 32'h0000_FF0F}
  };

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, {64'd0, bus_rdata}, {64'd0, exp});
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 irq", {95'd0, irq}, 96'd0);
    rd("R1 bank0 dir", 8'h24, 0);
    rd("R1 bank1 rise en", 8'h40, 0);
    rd("R1 bank2 data", 8'h70, 0);

    // R3 R4 R5 R6 R7 vector walk
    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd($sformatf("R3 R4 R5 R6 R7 vector %0d", i), VEC[i][39:32], VEC[i][31:0]);
    end

    // R2 R7 R10 pad-side view
    chk("R2 R10 pad_oe", pad_oe, {32'h0000_00FF, 32'hFFFF_0000, 32'hFFFF_FFFF});
    chk("R7 R10 pad_out", pad_out, {32'h0000_F00F, 32'h5555_5555, 32'h0000_01CE});
    rd("R3 set alias reads zero", 8'h2C, 0);

    // R8 rising edge with enable, bank1 pin 0 (pad 32)
    wr(8'h40, 32'h1);
    pad_in[32] = 1;
    tick(2);
    chk("R8 irq not before third edge", {95'd0, irq}, 96'd0);
    rd("R6 data after two edges", 8'h48, 32'h5555_0001);
    tick(1);
    chk("R8 R9 irq on rising", {95'd0, irq}, 96'd1);
    rd("R8 int status rise", 8'h38, 32'h1);
    rd("R8 edge status rise", 8'h3C, 32'h1);
    wr(8'h38, 32'h0);
    rd("R9 write zero keeps status", 8'h38, 32'h1);
    wr(8'h38, 32'h1);
    chk("R9 irq cleared", {95'd0, irq}, 96'd0);
    wr(8'h3C, 32'h1);
    rd("R9 edge status cleared", 8'h3C, 32'h0);

    // R8 falling without falling enable
    pad_in[32] = 0;
    tick(3);
    rd("R8 fall not enabled int", 8'h38, 32'h0);
    rd("R8 fall sets edge status", 8'h3C, 32'h1);
    chk("R8 irq stays low", {95'd0, irq}, 96'd0);

    // R8 falling enabled on pin 1 (pad 33)
    wr(8'h44, 32'h2);
    pad_in[33] = 1;
    tick(3);
    rd("R8 rise gated off", 8'h38, 32'h0);
    rd("R8 edge status both", 8'h3C, 32'h3);
    pad_in[33] = 0;
    tick(3);
    rd("R8 fall enabled int", 8'h38, 32'h2);
    chk("R9 irq on fall", {95'd0, irq}, 96'd1);
    wr(8'h38, 32'h2);
    chk("R9 irq clear after fall", {95'd0, irq}, 96'd0);

    // R8 output pins ignore pad edges, bank0 pin 0
    wr(8'h08, 32'hFFFF_FFFF);
    pad_in[0] = 1;
    tick(3);
    rd("R8 output pin int", 8'h00, 32'h0);
    rd("R8 output pin edge", 8'h04, 32'h0);
    rd("R6 output pin data is latch", 8'h20, 32'h0000_01CE);
    chk("R8 output pin irq", {95'd0, irq}, 96'd0);

    // R7 R8 inverted pin 8 of bank2 (pad 72): pad rise is a logical fall
    wr(8'h6C, 32'h100);
    pad_in[72] = 1;
    tick(3);
    rd("R7 R8 inverted edge int", 8'h60, 32'h100);
    rd("R6 R7 inverted data", 8'h70, 32'h0000_FE0F);
    chk("R9 R10 irq from bank2", {95'd0, irq}, 96'd1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule